// File: doc/BRIEF.md
# I2C Register Slave with Strap Address and Port Snapshot

This block is the serial front end of a small peripheral: an I2C-compatible slave that gives a bus master byte access to a bank of eight 8-bit registers. SCL and SDA arrive as raw pad levels. Each one passes through a two-flop synchronizer, and every bus event is recognised from edges in the fast system clock domain. The slave answers a 7-bit address. The upper five address bits are a fixed prefix (binary 10110). The lower two bits come from strap pins, so four copies can share one bus.

A write carries a command byte that selects a register, followed by data bytes for that register. A read sets the command byte with a write, then issues a repeated START with the read bit set, and the slave shifts the register out. Registers 0 and 1 are read-only. They return a snapshot of two 8-bit input ports, taken by a one-cycle strobe that fires while the slave acknowledges its own address. Registers 2 to 7 are writable and appear on a flat output bus. A separate active-low bus-reset pin aborts any transfer at any moment and leaves the register contents as they were.

Top module: `i2cs_regport`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal {10110, strap_i[1], strap_i[0]} by pulling SDA low (sda_oe_o = 1) during the ninth clock. Bit 0 of the byte selects write (0) or read (1).
- R2: After an address that does not match, the slave keeps SDA released and ignores every following byte, with no acknowledge and no register change, until the next START or STOP.
- R3: In a write, the slave acknowledges the byte after the address as a command and then every data byte. A data byte for command n (2 ≤ n ≤ 7) lands on ctrl_regs_o[(n-2)*8 +: 8]. Registers change only through such writes.
- R4: A read (address write, command, repeated START, address with read bit) returns the selected register MSB first, and a START from any state restarts address reception.
- R5: Commands 0 and 1 read port_i[7:0] and port_i[15:8] as captured at the latest address acknowledge. Port changes after that point do not affect the byte. Writes to commands 0 and 1 are acknowledged and discarded.
- R6: A command value above 7 is acknowledged, writes with it change nothing, and reads with it return 0x00.
- R7: sample_stb_o is a single-cycle pulse inside the acknowledge clock of a matching address, one per matching address byte in either direction, and never for a foreign address.
- R8: Holding bus_rst_n low abandons the transfer in progress: SDA is released, the register contents stay, later clocks draw no acknowledge until a new START, and the next transaction works normally.
- R9: When the master acknowledges a read byte, the same register is sent again. After a master non-acknowledge, the slave keeps SDA released until the next START or STOP.
- R10: Outside bus reset, the slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low system reset, clears registers and state |
| bus_rst_n | input | 1 | Active-low bus abort pin, asynchronous to clk |
| scl_i | input | 1 | Serial clock level from the pad |
| sda_i | input | 1 | Serial data level from the pad (wired bus value) |
| strap_i | input | 2 | Strap pins forming the two low address bits |
| port_i | input | 16 | Input ports: [7:0] read at command 0, [15:8] at command 1 |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| sample_stb_o | output | 1 | One-cycle port-sample strobe at own address acknowledge |
| ctrl_regs_o | output | 48 | Writable registers 2..7, register n at bits (n-2)*8 +: 8 |

## Verification
The in-line properties assume a bus master that moves SDA only while SCL is low, except to form START and STOP. They also assume that SCL low phases last many system clocks, so that the registered SDA drive settles while the synchronized clock is still low. They further assume that no START or STOP comes while the slave itself holds SDA low. The stimulus meets these assumptions by driving every bit on a fixed grid of ten-clock quarter periods. It ends each read with a non-acknowledge before the STOP and asserts the bus reset only during an SCL low phase. Randomly chosen register writes and reads, including out-of-range commands and changing port values, are mixed with directed abort, foreign-address and repeat-read cases.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_HUSH
   } bus_st_e;

   typedef enum logic [1:0] {
      FLD_ADDR,
      FLD_CMD,
      FLD_DATA
   } fld_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cs_sync needs at least two stages");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{IDLE_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
   end
endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
   import i2cs_pkg::*;
#(
   parameter int DW = 8,
   parameter int NREG = 8,
   parameter int RO_REGS = 2,
   parameter int ADDR_W = 7,
   parameter int PREFIX_W = 5,
   parameter logic [PREFIX_W-1:0] PREFIX = 5'b10110,
   localparam int IDX_W = $clog2(NREG),
   localparam int SW = ADDR_W - PREFIX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   input  logic             brst_n_s,
   input  logic [SW-1:0]    strap_i,
   input  logic [DW-1:0]    rd_data_i,
   output logic             sda_oe_o,
   output logic             stb_o,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] sel_idx_o,
   output logic [DW-1:0]    wr_data_o
);
   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DW);
   localparam logic [CW-1:0] LAST_TX = CW'(DW - 1);
   localparam logic [DW:0] NREG_V = (DW + 1)'(NREG);
   localparam logic [IDX_W-1:0] RO_V = IDX_W'(RO_REGS);

   bus_st_e          state;
   fld_e             fld;
   logic             scl_q, sda_q;
   logic [CW-1:0]    bitcnt;
   logic [DW-1:0]    shreg;
   logic             rw, cmd_ok, mack;
   logic [IDX_W-1:0] ptr;
   logic [DW-1:0]    tx_byte;

   wire scl_rise = scl_s & ~scl_q;
   wire scl_fall = ~scl_s & scl_q;
   wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
   wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

   assign tx_byte   = cmd_ok ? rd_data_i : '0;
   assign sel_idx_o = ptr;
   assign wr_data_o = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         fld      <= FLD_ADDR;
         bitcnt   <= '0;
         shreg    <= '0;
         rw       <= 1'b0;
         cmd_ok   <= 1'b1;
         mack     <= 1'b0;
         ptr      <= '0;
         sda_oe_o <= 1'b0;
         stb_o    <= 1'b0;
         wr_en_o  <= 1'b0;
      end else begin
         stb_o   <= 1'b0;
         wr_en_o <= 1'b0;
         if (!brst_n_s) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
         end else if (start_c) begin
            state    <= ST_RX;
            fld      <= FLD_ADDR;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_c) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && bitcnt < FULL_CNT) begin
                     shreg  <= {shreg[DW-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == FULL_CNT) begin
                     case (fld)
                        FLD_ADDR: begin
                           if (shreg[DW-1:1] == {PREFIX, strap_i}) begin
                              rw       <= shreg[0];
                              stb_o    <= 1'b1;
                              sda_oe_o <= 1'b1;
                              state    <= ST_ACK;
                           end else begin
                              state <= ST_HUSH;
                           end
                        end
                        FLD_CMD: begin
                           ptr      <= shreg[IDX_W-1:0];
                           cmd_ok   <= ({1'b0, shreg} < NREG_V);
                           sda_oe_o <= 1'b1;
                           state    <= ST_ACK;
                        end
                        default: begin
                           wr_en_o  <= cmd_ok && (ptr >= RO_V);
                           sda_oe_o <= 1'b1;
                           state    <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (fld == FLD_ADDR && rw) begin
                        state    <= ST_TX;
                        shreg    <= tx_byte;
                        sda_oe_o <= ~tx_byte[DW-1];
                     end else begin
                        state    <= ST_RX;
                        fld      <= (fld == FLD_ADDR) ? FLD_CMD : FLD_DATA;
                        sda_oe_o <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == LAST_TX) begin
                        state    <= ST_MACK;
                        sda_oe_o <= 1'b0;
                     end else begin
                        shreg    <= {shreg[DW-2:0], 1'b0};
                        sda_oe_o <= ~shreg[DW-2];
                        bitcnt   <= bitcnt + 1'b1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        state    <= ST_TX;
                        bitcnt   <= '0;
                        shreg    <= tx_byte;
                        sda_oe_o <= ~tx_byte[DW-1];
                     end else begin
                        state <= ST_HUSH;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R10
   sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe_o) && brst_n_s && $past(brst_n_s)) |-> !scl_s);

   // R7
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |=> !stb_o);

   // R8
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !brst_n_s |=> !sda_oe_o);

   // R2
   hush_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HUSH && $past(state == ST_HUSH)) |-> !sda_oe_o);
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
   parameter int DW = 8,
   parameter int NREG = 8,
   parameter int RO_REGS = 2,
   localparam int IDX_W = $clog2(NREG),
   localparam int WR_REGS = NREG - RO_REGS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  snap_en_i,
   input  logic [RO_REGS*DW-1:0] port_i,
   input  logic                  wr_en_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic [DW-1:0]         wr_data_i,
   output logic [DW-1:0]         rd_data_o,
   output logic [WR_REGS*DW-1:0] ctrl_o
);
   localparam logic [IDX_W-1:0] RO_V = IDX_W'(RO_REGS);

   logic [DW-1:0] bank [NREG];

   for (genvar g = 0; g < RO_REGS; g++) begin : g_snap
      logic [DW-1:0] snap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         snap_q <= '0;
         else if (snap_en_i) snap_q <= port_i[g*DW +: DW];
      end
      assign bank[g] = snap_q;
   end

   for (genvar g = RO_REGS; g < NREG; g++) begin : g_wr
      logic [DW-1:0] reg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) reg_q <= '0;
         else if (wr_en_i && idx_i == IDX_W'(g)) reg_q <= wr_data_i;
      end
      assign bank[g] = reg_q;
      assign ctrl_o[(g-RO_REGS)*DW +: DW] = reg_q;
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NREG; i++) begin
         if (idx_i == IDX_W'(i)) rd_data_o = bank[i];
      end
   end

   // R5
   ro_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |-> idx_i >= RO_V);

   // R3
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(ctrl_o));
endmodule

// File: rtl/i2cs_regport.sv
module i2cs_regport #(
   parameter int DW = 8,
   parameter int NREG = 8,
   parameter int RO_REGS = 2,
   parameter int ADDR_W = 7,
   parameter int PREFIX_W = 5,
   parameter logic [PREFIX_W-1:0] PREFIX = 5'b10110,
   parameter int SYNC_STAGES = 2,
   localparam int SW = ADDR_W - PREFIX_W,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_rst_n,
   input  logic                         scl_i,
   input  logic                         sda_i,
   input  logic [SW-1:0]                strap_i,
   input  logic [RO_REGS*DW-1:0]        port_i,
   output logic                         sda_oe_o,
   output logic                         sample_stb_o,
   output logic [(NREG-RO_REGS)*DW-1:0] ctrl_regs_o
);
   if (DW != ADDR_W + 1) begin : g_bad_dw
      $error("address plus direction bit must fill one byte");
   end
   if (RO_REGS < 1 || RO_REGS >= NREG) begin : g_bad_ro
      $error("read-only count must leave writable registers");
   end
   if (PREFIX_W >= ADDR_W) begin : g_bad_prefix
      $error("address prefix must leave strap bits");
   end
   if ((1 << IDX_W) != NREG || NREG > (1 << DW)) begin : g_bad_nreg
      $error("register count must be a power of two reachable by a command byte");
   end

   logic [2:0]       raw, synced;
   logic             stb, wr_en;
   logic [IDX_W-1:0] idx;
   logic [DW-1:0]    wr_data, rd_data;

   assign raw = {bus_rst_n, sda_i, scl_i};
   assign sample_stb_o = stb;

   i2cs_sync #(
      .WIDTH(3), .STAGES(SYNC_STAGES), .IDLE_VAL(3'b111)
   ) i_sync (
      .clk(clk), .rst_n(rst_n), .din(raw), .dout(synced)
   );

   i2cs_proto #(
      .DW(DW), .NREG(NREG), .RO_REGS(RO_REGS), .ADDR_W(ADDR_W),
      .PREFIX_W(PREFIX_W), .PREFIX(PREFIX)
   ) i_proto (
      .clk(clk), .rst_n(rst_n),
      .scl_s(synced[0]), .sda_s(synced[1]), .brst_n_s(synced[2]),
      .strap_i(strap_i), .rd_data_i(rd_data),
      .sda_oe_o(sda_oe_o), .stb_o(stb), .wr_en_o(wr_en),
      .sel_idx_o(idx), .wr_data_o(wr_data)
   );

   i2cs_regbank #(
      .DW(DW), .NREG(NREG), .RO_REGS(RO_REGS)
   ) i_bank (
      .clk(clk), .rst_n(rst_n), .snap_en_i(stb), .port_i(port_i),
      .wr_en_i(wr_en), .idx_i(idx), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .ctrl_o(ctrl_regs_o)
   );
endmodule

// File: tb/test_i2cs_regport.sv
`timescale 1ns/1ps
module test_i2cs_regport;
   localparam int Q = 10;
   localparam logic [1:0] STRAP = 2'b10;
   localparam logic [6:0] ME = {5'b10110, STRAP};
   localparam logic [6:0] OTHER = {5'b10110, 2'b01};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rst_n = 1'b1;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [15:0] port_v = 16'h0000;
   logic        sda_oe, stb;
   logic [47:0] ctrl;
   wire         sda_line = sda_m & ~sda_oe;

   int compared = 0;
   int mismatched = 0;
   int stb_cnt = 0;
   int stb_wide = 0;
   int sda_hi_change = 0;
   logic stb_prev = 1'b0;
   logic oe_prev = 1'b0;
   logic [7:0] model [8];

   always #4 clk = ~clk;

   i2cs_regport i_i2cs_regport (
      .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
      .scl_i(scl_m), .sda_i(sda_line), .strap_i(STRAP), .port_i(port_v),
      .sda_oe_o(sda_oe), .sample_stb_o(stb), .ctrl_regs_o(ctrl)
   );

   always @(negedge clk) begin
      if (stb) stb_cnt++;
      if (stb && stb_prev) stb_wide++;
      if (rst_n && bus_rst_n && scl_m && (sda_oe != oe_prev)) sda_hi_change++;
      stb_prev = stb;
      oe_prev = sda_oe;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [47:0] exp_ctrl();
      logic [47:0] v;
      for (int i = 2; i < 8; i++) v[(i-2)*8 +: 8] = model[i];
      return v;
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] c, input logic [15:0] p);
      if (c == 8'd0) return p[7:0];
      if (c == 8'd1) return p[15:8];
      if (c < 8'd8) return model[c[2:0]];
      return 8'h00;
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clk_bit(input logic b, output logic s);
      wait_clk(Q); sda_m = b;
      wait_clk(Q); scl_m = 1'b1;
      repeat (Q) @(negedge clk);
      s = sda_line;
      wait_clk(Q); scl_m = 1'b0;
   endtask

   task automatic bus_start();
      if (scl_m == 1'b0) begin
         wait_clk(Q); sda_m = 1'b1;
         wait_clk(Q); scl_m = 1'b1;
      end
      wait_clk(Q); sda_m = 1'b0;
      wait_clk(Q); scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      wait_clk(Q); sda_m = 1'b0;
      wait_clk(Q); scl_m = 1'b1;
      wait_clk(Q); sda_m = 1'b1;
      wait_clk(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         b[i] = s;
      end
      clk_bit(~mack, s);
   endtask

   task automatic wr_reg(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                         output logic [2:0] acks);
      bus_start();
      send_byte({a, 1'b0}, acks[2]);
      send_byte(c, acks[1]);
      send_byte(d, acks[0]);
      bus_stop();
   endtask

   task automatic rd_reg(input logic [7:0] c, output logic [7:0] d, output logic [2:0] acks);
      bus_start();
      send_byte({ME, 1'b0}, acks[2]);
      send_byte(c, acks[1]);
      bus_start();
      send_byte({ME, 1'b1}, acks[0]);
      recv_byte(1'b0, d);
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [2:0] acks;
      logic [7:0] got, got2;
      logic s, a;
      int n0;
      void'($urandom(32'd20251));
      for (int i = 0; i < 8; i++) model[i] = 8'h00;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      // reset state
      check("R8 reset sda_oe", sda_oe, 0);
      check("R7 reset strobe", stb, 0);
      check("R3 reset ctrl", ctrl, 48'h0);

      // R1 R3 R7 directed write
      n0 = stb_cnt;
      wr_reg(ME, 8'd2, 8'hA5, acks);
      model[2] = 8'hA5;
      check("R1 R3 write acks", acks, 3'b111);
      check("R3 write lands", ctrl, exp_ctrl());
      check("R7 one strobe on write", stb_cnt - n0, 1);

      // R4 read back with repeated START
      n0 = stb_cnt;
      rd_reg(8'd2, got, acks);
      check("R4 read acks", acks, 3'b111);
      check("R4 read data", got, 8'hA5);
      check("R7 two strobes on read", stb_cnt - n0, 2);

      // R2 foreign address
      n0 = stb_cnt;
      wr_reg(OTHER, 8'd3, 8'h5C, acks);
      check("R2 foreign no ack", acks, 3'b000);
      check("R2 foreign no write", ctrl, exp_ctrl());
      check("R7 no strobe foreign", stb_cnt - n0, 0);

      // R5 write to read-only discarded, snapshot at address ack
      wr_reg(ME, 8'd0, 8'hFF, acks);
      check("R5 ro write acked", acks, 3'b111);
      check("R5 ro write discarded", ctrl, exp_ctrl());
      port_v = 16'h3C96;
      bus_start();
      send_byte({ME, 1'b0}, a);
      send_byte(8'd1, a);
      bus_start();
      send_byte({ME, 1'b1}, a);
      port_v = 16'hFFFF;
      recv_byte(1'b0, got);
      bus_stop();
      check("R5 snapshot held", got, 8'h3C);

      // R6 out-of-range command
      wr_reg(ME, 8'd9, 8'h11, acks);
      check("R6 big cmd acked", acks, 3'b111);
      check("R6 big cmd no effect", ctrl, exp_ctrl());
      rd_reg(8'd12, got, acks);
      check("R6 big cmd reads zero", got, 8'h00);

      // R9 repeat on master ack, release after nack
      wr_reg(ME, 8'd4, 8'h81, acks);
      model[4] = 8'h81;
      bus_start();
      send_byte({ME, 1'b0}, a);
      send_byte(8'd4, a);
      bus_start();
      send_byte({ME, 1'b1}, a);
      recv_byte(1'b1, got);
      recv_byte(1'b0, got2);
      check("R9 first byte", got, 8'h81);
      check("R9 repeated byte", got2, 8'h81);
      recv_byte(1'b0, got);
      check("R9 released after nack", got, 8'hFF);
      bus_stop();

      // R8 bus reset mid data byte
      wr_reg(ME, 8'd3, 8'h3C, acks);
      model[3] = 8'h3C;
      bus_start();
      send_byte({ME, 1'b0}, a);
      send_byte(8'd3, a);
      for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
      bus_rst_n = 1'b0;
      wait_clk(6);
      bus_rst_n = 1'b1;
      wait_clk(6);
      check("R8 sda released", sda_oe, 0);
      for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
      clk_bit(1'b1, s);
      check("R8 no ack after abort", s, 1);
      bus_stop();
      check("R8 regs kept", ctrl, exp_ctrl());
      wr_reg(ME, 8'd3, 8'h77, acks);
      model[3] = 8'h77;
      check("R8 next transaction acks", acks, 3'b111);
      check("R8 next transaction writes", ctrl, exp_ctrl());

      // random mix
      for (int it = 0; it < 30; it++) begin
         logic [7:0] c, d, r;
         logic [2:0] k;
         c = 8'($urandom % 10);
         d = 8'($urandom);
         if ($urandom % 2 == 0) begin
            wr_reg(ME, c, d, k);
            if (c >= 8'd2 && c < 8'd8) model[c[2:0]] = d;
            check("R3 random write acks", k, 3'b111);
            check("R3 R5 R6 random ctrl", ctrl, exp_ctrl());
         end else begin
            port_v = 16'($urandom);
            rd_reg(c, r, k);
            check("R4 random read acks", k, 3'b111);
            check("R4 R5 R6 random read", r, exp_read(c, port_v));
         end
      end

      check("R7 strobe width", stb_wide, 0);
      check("R10 sda changes only with scl low", sda_hi_change, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule